// File: doc/BRIEF.md
# Dual-Tone Keypad Signal Generator

This block turns a 4-bit keypad code into a two-tone signalling waveform delivered as signed digital samples. Each key pairs one frequency from a low group (697, 770, 852, 941 Hz) with one from a high group (1209, 1336, 1477, 1633 Hz). Two 24-bit phase accumulators advance once per master clock cycle at 3.579545 MHz. Each accumulator addresses a 256-entry signed sine table. The two table outputs are weighted so that the high tone sits about 2 dB above the low tone, then summed. An optional halving applies 6 dB of attenuation.

A burst starts when the tone enable rises. The code is captured at that edge and both phases restart from zero. Later code changes have no effect until the next rise. Samples leave at an 8 kHz rate, each marked by a one-cycle strobe. While the enable is low the strobes continue but every sample is zero. Digital-to-analog conversion and any filtering are left to the surrounding design.

Top module: `dtg_tone_gen`

## Requirements
- R1: With synchronous reset (`rst` high) applied, `sample` is 0 and `sample_vld` is 0 after the next clock edge.
- R2: `sample_vld` is a one-cycle pulse, and the pulses occur every 447 master cycles (clock rate / 8000, truncated). After a rise of `tone_en` that is sampled at edge k, the first pulse follows edge k+447.
- R3: Key code mapping, as (low Hz, high Hz): 1=(697,1209), 2=(697,1336), 3=(697,1477), 4=(770,1209), 5=(770,1336), 6=(770,1477), 7=(852,1209), 8=(852,1336), 9=(852,1477), 10=(941,1336), 11=(941,1209), 12=(941,1477), 13=(697,1633), 14=(770,1633), 15=(852,1633), 0=(941,1633).
- R4: Each tone uses a 24-bit phase accumulator that adds round(f * 2^24 / 3579545) every cycle and wraps modulo 2^24. Bits 23:16 give the table index. With this rounding every tone lies within 0.01% of nominal, well inside ±1.5%.
- R5: Sine table entry i (0..255): let x = i mod 128 and m = floor(16*32767*x*(128-x) / (81920 - 4*x*(128-x))). The entry is m for i < 128 and -m otherwise.
- R6: Sample value = (Shi*128 >>> 8) + (Slo*102 >>> 8), where Shi and Slo are the high and low table entries and >>> is an arithmetic (flooring) shift. This gives a high-to-low level ratio of about 1.97 dB.
- R7: When `atten` is 1 at the strobe edge, the R6 value is arithmetically shifted right by one bit, halving the amplitude (-6 dB).
- R8: `key_code` is captured only at the edge where `tone_en` is sampled high after having been low. Changes while `tone_en` stays high do not alter the frequencies.
- R9: Both accumulators are zero after the rise edge k. The sample posted at edge k+447*j uses phases (447*j-1)*inc for each tone.
- R10: Whenever `tone_en` is sampled low, `sample` is 0 after that edge, and strobes keep coming with zero samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, nominally 3.579545 MHz |
| rst | input | 1 | Synchronous reset, active high |
| tone_en | input | 1 | Tone enable; a rise starts a burst and captures the code |
| key_code | input | 4 | Keypad code, mapped as in R3 |
| atten | input | 1 | 1 halves the output amplitude |
| sample | output | 16 | Signed output sample |
| sample_vld | output | 1 | One-cycle strobe marking a new sample |

## Verification
Bursts are run for several keys that cover every row and every column of the keypad grid, including the code 0 key that selects the 941/1633 pair. A wrong row or column decode therefore changes the predicted sample values. One key is repeated with attenuation on, so that the halving is distinguished from the 2 dB group weighting. Another burst changes the code partway through, which shows whether the captured pair really holds. An idle stretch and the cycle right after each enable drop separate the silent output from a stopped strobe. Each burst checks the strobe on every cycle, which pins down the 447-cycle divider and the phase restart at the enable rise.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    // Rounded phase step for a tone of f_hz at clock clk_hz, accw-bit accumulator
    function automatic longint phase_inc(longint f_hz, longint clk_hz, int accw);
        longint scaled;
        scaled = f_hz << (accw + 1);
        return (scaled + clk_hz) / (2 * clk_hz);
    endfunction

    // Rational sine approximation over one period of 2**aw points, dw-bit signed
    function automatic longint sine_pt(int i, int aw, int dw);
        longint half;
        longint x;
        longint amp;
        longint prod;
        longint mag;
        half = longint'(1) << (aw - 1);
        x    = longint'(i) % half;
        amp  = (longint'(1) << (dw - 1)) - 1;
        prod = x * (half - x);
        mag  = (16 * amp * prod) / (5 * half * half - 4 * prod);
        return (longint'(i) >= half) ? -mag : mag;
    endfunction

endpackage

// File: rtl/dtg_key_decode.sv
module dtg_key_decode #(
    parameter int CLK_HZ = 3579545,
    parameter int ACC_W  = 24
) (
    input  logic [3:0]       code,
    output logic [ACC_W-1:0] inc_lo,
    output logic [ACC_W-1:0] inc_hi
);
    localparam logic [ACC_W-1:0] LO_TAB [4] = '{
        ACC_W'(dtg_pkg::phase_inc(697, CLK_HZ, ACC_W)),
        ACC_W'(dtg_pkg::phase_inc(770, CLK_HZ, ACC_W)),
        ACC_W'(dtg_pkg::phase_inc(852, CLK_HZ, ACC_W)),
        ACC_W'(dtg_pkg::phase_inc(941, CLK_HZ, ACC_W))
    };
    localparam logic [ACC_W-1:0] HI_TAB [4] = '{
        ACC_W'(dtg_pkg::phase_inc(1209, CLK_HZ, ACC_W)),
        ACC_W'(dtg_pkg::phase_inc(1336, CLK_HZ, ACC_W)),
        ACC_W'(dtg_pkg::phase_inc(1477, CLK_HZ, ACC_W)),
        ACC_W'(dtg_pkg::phase_inc(1633, CLK_HZ, ACC_W))
    };

    logic [1:0] row;
    logic [1:0] col;

    // R3: keypad grid position for every code
    always_comb begin
        case (code)
            4'd1:    begin row = 2'd0; col = 2'd0; end
            4'd2:    begin row = 2'd0; col = 2'd1; end
            4'd3:    begin row = 2'd0; col = 2'd2; end
            4'd4:    begin row = 2'd1; col = 2'd0; end
            4'd5:    begin row = 2'd1; col = 2'd1; end
            4'd6:    begin row = 2'd1; col = 2'd2; end
            4'd7:    begin row = 2'd2; col = 2'd0; end
            4'd8:    begin row = 2'd2; col = 2'd1; end
            4'd9:    begin row = 2'd2; col = 2'd2; end
            4'd10:   begin row = 2'd3; col = 2'd1; end
            4'd11:   begin row = 2'd3; col = 2'd0; end
            4'd12:   begin row = 2'd3; col = 2'd2; end
            4'd13:   begin row = 2'd0; col = 2'd3; end
            4'd14:   begin row = 2'd1; col = 2'd3; end
            4'd15:   begin row = 2'd2; col = 2'd3; end
            default: begin row = 2'd3; col = 2'd3; end
        endcase
    end

    assign inc_lo = LO_TAB[row];
    assign inc_hi = HI_TAB[col];
endmodule

// File: rtl/dtg_phase_acc.sv
module dtg_phase_acc #(
    parameter int ACC_W = 24,
    parameter int AW    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [ACC_W-1:0] inc,
    output logic [AW-1:0]    idx
);
    logic [ACC_W-1:0] acc_d;
    logic [ACC_W-1:0] acc_q;

    // R4/R9: restart at zero on a new burst, otherwise wrap-around add
    always_comb begin
        if (clr) acc_d = '0;
        else     acc_d = acc_q + inc;
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
    end

    assign idx = acc_q[ACC_W-1 -: AW];
endmodule

// File: rtl/dtg_sine_rom.sv
module dtg_sine_rom #(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic [AW-1:0]        addr,
    output logic signed [DW-1:0] data
);
    localparam int DEPTH = 2 ** AW;

    logic signed [DW-1:0] tbl [DEPTH];

    // R5: table contents computed at elaboration
    for (genvar i = 0; i < DEPTH; i++) begin : g_pt
        assign tbl[i] = DW'(dtg_pkg::sine_pt(i, AW, DW));
    end

    assign data = tbl[addr];
endmodule

// File: rtl/dtg_tone_gen.sv
module dtg_tone_gen #(
    parameter int CLK_HZ    = 3579545,
    parameter int SAMPLE_HZ = 8000,
    parameter int ACC_W     = 24,
    parameter int AW        = 8,
    parameter int DW        = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tone_en,
    input  logic [3:0]           key_code,
    input  logic                 atten,
    output logic signed [DW-1:0] sample,
    output logic                 sample_vld
);
    localparam int DIV  = CLK_HZ / SAMPLE_HZ;
    localparam int CW   = $clog2(DIV + 1);
    localparam int GSH  = 8;
    localparam int MW   = DW + GSH + 2;
    localparam logic signed [MW-1:0] G_HI = MW'(128);
    localparam logic signed [MW-1:0] G_LO = MW'(102);

    typedef struct packed {
        logic                 en;
        logic [3:0]           code;
        logic [CW-1:0]        cnt;
        logic signed [DW-1:0] smp;
        logic                 vld;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic                 rise;
    logic                 tick;
    logic [ACC_W-1:0]     inc  [2];
    logic [AW-1:0]        idx  [2];
    logic signed [DW-1:0] tone [2];
    logic [AW-1:0]        idx_lo;
    logic [AW-1:0]        idx_hi;
    logic signed [MW-1:0] p_lo;
    logic signed [MW-1:0] p_hi;
    logic signed [MW-1:0] mix;

    assign rise = tone_en && !st_q.en;
    assign tick = (st_q.cnt == CW'(DIV - 1));

    dtg_key_decode #(.CLK_HZ(CLK_HZ), .ACC_W(ACC_W)) i_dec (
        .code   (st_q.code),
        .inc_lo (inc[0]),
        .inc_hi (inc[1])
    );

    // index 0: low group, index 1: high group
    for (genvar g = 0; g < 2; g++) begin : g_tone
        dtg_phase_acc #(.ACC_W(ACC_W), .AW(AW)) i_acc (
            .clk (clk),
            .rst (rst),
            .clr (rise),
            .inc (inc[g]),
            .idx (idx[g])
        );
        dtg_sine_rom #(.AW(AW), .DW(DW)) i_rom (
            .addr (idx[g]),
            .data (tone[g])
        );
    end

    assign idx_lo = idx[0];
    assign idx_hi = idx[1];

    // R6/R7: weighted sum, optional halving
    always_comb begin
        p_hi = MW'(tone[1]) * G_HI;
        p_lo = MW'(tone[0]) * G_LO;
        mix  = (p_hi >>> GSH) + (p_lo >>> GSH);
        if (atten) mix = mix >>> 1;
    end

    always_comb begin
        st_d      = st_q;
        st_d.en   = tone_en;
        st_d.code = rise ? key_code : st_q.code;          // R8
        st_d.cnt  = (rise || tick) ? '0 : st_q.cnt + 1'b1; // R2
        st_d.vld  = tick && !rise;
        if (!tone_en || rise) st_d.smp = '0;               // R10
        else if (tick)        st_d.smp = DW'(mix);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;  // R1
        else     st_q <= st_d;
    end

    assign sample     = st_q.smp;
    assign sample_vld = st_q.vld;
endmodule

// File: rtl/dtg_tone_gen_chk.sv
module dtg_tone_gen_chk #(
    parameter int DIV = 447,
    parameter int DW  = 16,
    parameter int AW  = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 tone_en,
    input logic signed [DW-1:0] sample,
    input logic                 sample_vld,
    input logic [3:0]           code_q,
    input logic [AW-1:0]        idx_lo,
    input logic [AW-1:0]        idx_hi
);
    logic        en_prev;
    logic        seen;
    logic [31:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_prev <= 1'b0;
            seen    <= 1'b0;
            gap     <= '0;
        end else begin
            en_prev <= tone_en;
            if (tone_en && !en_prev) begin
                seen <= 1'b1;
                gap  <= '0;
            end else if (sample_vld) begin
                gap  <= 32'd1;
            end else begin
                gap  <= gap + 32'd1;
            end
        end
    end

    p_strobe_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        sample_vld |=> !sample_vld);

    p_strobe_gap_r2: assert property (@(posedge clk) disable iff (rst)
        (sample_vld && seen) |-> (gap == 32'(DIV)));

    p_silent_r10: assert property (@(posedge clk) disable iff (rst)
        !tone_en |=> (sample == '0));

    p_code_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (tone_en && $past(tone_en)) |=> $stable(code_q));

    p_phase_zero_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(tone_en) |=> (idx_lo == '0 && idx_hi == '0));
endmodule

bind dtg_tone_gen dtg_tone_gen_chk #(.DIV(DIV), .DW(DW), .AW(AW)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .tone_en    (tone_en),
    .sample     (sample),
    .sample_vld (sample_vld),
    .code_q     (st_q.code),
    .idx_lo     (idx_lo),
    .idx_hi     (idx_hi)
);

// File: tb/test_dtg_tone_gen.sv
`timescale 1ns/1ps
module test_dtg_tone_gen;
    localparam int DIV = 447;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tone_en = 1'b0;
    logic [3:0]  key_code = 4'd0;
    logic        atten = 1'b0;
    logic signed [15:0] sample;
    logic        sample_vld;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dtg_tone_gen i_dtg_tone_gen (
        .clk(clk), .rst(rst), .tone_en(tone_en), .key_code(key_code),
        .atten(atten), .sample(sample), .sample_vld(sample_vld)
    );

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R3 mapping
    function automatic void freqs(input int c, output int lo, output int hi);
        case (c)
            1: begin lo = 697; hi = 1209; end
            2: begin lo = 697; hi = 1336; end
            3: begin lo = 697; hi = 1477; end
            4: begin lo = 770; hi = 1209; end
            5: begin lo = 770; hi = 1336; end
            6: begin lo = 770; hi = 1477; end
            7: begin lo = 852; hi = 1209; end
            8: begin lo = 852; hi = 1336; end
            9: begin lo = 852; hi = 1477; end
            10: begin lo = 941; hi = 1336; end
            11: begin lo = 941; hi = 1209; end
            12: begin lo = 941; hi = 1477; end
            13: begin lo = 697; hi = 1633; end
            14: begin lo = 770; hi = 1633; end
            15: begin lo = 852; hi = 1633; end
            default: begin lo = 941; hi = 1633; end
        endcase
    endfunction

    // R4 step, rounded with real arithmetic
    function automatic longint step(int f);
        return longint'($rtoi(real'(f) * 16777216.0 / 3579545.0 + 0.5));
    endfunction

    // R5 table entry
    function automatic int tab(longint i);
        longint x = i % 128;
        longint p = x * (128 - x);
        longint m = (16 * 32767 * p) / (81920 - 4 * p);
        return int'((i >= 128) ? -m : m);
    endfunction

    // R6/R7/R9 expected j-th sample of a burst
    function automatic int model(int c, int j, bit att);
        int lo, hi, v;
        longint n, plo, phi;
        freqs(c, lo, hi);
        n   = longint'(j) * DIV - 1;
        plo = (n * step(lo)) % 16777216;
        phi = (n * step(hi)) % 16777216;
        v = ((tab(phi >> 16) * 128) >>> 8) + ((tab(plo >> 16) * 102) >>> 8);
        if (att) v = v >>> 1;
        return v;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        check("R1", "sample after reset", sample, 0);
        check("R1", "strobe after reset", sample_vld, 0);
    endtask

    task automatic t_idle();
        int strobes = 0;
        int nonzero = 0;
        for (int m = 0; m < 2 * DIV + 3; m++) begin
            @(negedge clk);
            if (sample_vld) begin
                strobes++;
                if (sample != 0) nonzero++;
            end
        end
        check("R10", "strobes while idle", strobes, 2);
        check("R10", "nonzero idle samples", nonzero, 0);
    endtask

    // one burst of nsmp samples; optionally change the code midway
    task automatic t_burst(string req, int c, bit att, int nsmp, bit chg);
        int bad_vld = 0;
        int bad_smp = 0;
        @(negedge clk);
        key_code = 4'(c);
        atten    = att;
        tone_en  = 1'b1;
        @(negedge clk);  // rise edge k has passed
        for (int m = 1; m <= nsmp * DIV; m++) begin
            @(negedge clk);
            if (chg && m == DIV + 5) key_code = 4'(c ^ 4'h5);
            if (sample_vld != (m % DIV == 0)) bad_vld++;
            if (sample_vld && (m % DIV == 0)) begin
                check(req, $sformatf("code %0d sample %0d", c, m / DIV),
                      sample, model(c, m / DIV, att));
            end
        end
        check("R2", $sformatf("strobe timing code %0d", c), bad_vld, 0);
        tone_en = 1'b0;
        @(negedge clk);
        check("R10", "sample right after disable", sample, 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_idle();
        t_burst("R3", 1, 1'b0, 3, 1'b0);
        t_burst("R3", 5, 1'b0, 3, 1'b0);
        t_burst("R3", 9, 1'b0, 2, 1'b0);
        t_burst("R3", 10, 1'b0, 2, 1'b0);
        t_burst("R3", 11, 1'b0, 2, 1'b0);
        t_burst("R3", 12, 1'b0, 2, 1'b0);
        t_burst("R3", 0, 1'b0, 2, 1'b0);
        t_burst("R6", 14, 1'b0, 3, 1'b0);
        t_burst("R7", 14, 1'b1, 3, 1'b0);
        t_burst("R8", 7, 1'b0, 4, 1'b1);
        t_burst("R9", 3, 1'b0, 2, 1'b0);
        t_burst("R4", 13, 1'b0, 4, 1'b0);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(150000 * 10);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule